// File: doc/BRIEF.md
# Packet Sync and CRC Status Tracker

This block follows a packet engine through each packet and keeps three status flags for it. The first flag, `in_pkt`, is high while a packet is in flight. A sync-word strobe sets it. End of packet clears it. A fault in the current direction also clears it: an address mismatch or a receive FIFO overflow while receiving, or a transmit FIFO underflow while transmitting.

The second flag, `pkt_good`, is high once a packet has finished with a passing CRC. It drops when software pulls the first byte of that packet out of the receive FIFO. The third flag, `crc_match`, shows the result of the most recent CRC comparison. It is wiped whenever the receiver is entered or restarted.

Every flag is registered, so each one reacts in the clock cycle after its cause. A parameter mask can invert each output for boards that need active-low status lines.

Top module: `pkt_status_track`

## Requirements
- R1: After reset, with a zero inversion mask, `in_pkt`, `pkt_good` and `crc_match` are all 0.
- R2: A `sync_evt` pulse with no clearing event in the same cycle sets `in_pkt` in the next cycle. The flag then holds until a clearing event.
- R3: An `eop_evt` pulse clears `in_pkt` in the next cycle.
- R4: With `dir_tx`=0 (receive), `addr_fail` or `rx_ovf` clears `in_pkt` in the next cycle. `tx_udf` leaves `in_pkt` unchanged.
- R5: With `dir_tx`=1 (transmit), `tx_udf` clears `in_pkt` in the next cycle. `addr_fail` and `rx_ovf` leave `in_pkt` unchanged.
- R6: If a clearing event (end of packet, or an abort valid for the current direction) arrives in the same cycle as `sync_evt`, `in_pkt` is 0 in the next cycle.
- R7: `crc_done` with `crc_pass`=1 sets `pkt_good` in the next cycle. `crc_done` with `crc_pass`=0 never sets it.
- R8: `rx_rd` clears `pkt_good` in the next cycle when it is set. `rx_rd` while `pkt_good` is clear has no effect. A passing `crc_done` in the same cycle as `rx_rd` leaves `pkt_good` set.
- R9: On each `crc_done`, `crc_match` takes the value of `crc_pass` in the next cycle. Without `crc_done` or `rx_enter`, it holds.
- R10: `rx_enter` clears `crc_match` in the next cycle. This takes priority over a `crc_done` in the same cycle.
- R11: Parameter `INV_MASK` bit 0 inverts `in_pkt`, bit 1 inverts `pkt_good` and bit 2 inverts `crc_match`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_tx | input | 1 | 1 = transmit, 0 = receive; selects which aborts apply |
| sync_evt | input | 1 | Sync word sent or received |
| eop_evt | input | 1 | End of packet |
| addr_fail | input | 1 | Address check failed (receive) |
| rx_ovf | input | 1 | Receive FIFO overflow |
| tx_udf | input | 1 | Transmit FIFO underflow |
| crc_done | input | 1 | CRC comparison result valid |
| crc_pass | input | 1 | CRC comparison matched, qualified by crc_done |
| rx_rd | input | 1 | Byte read from receive FIFO |
| rx_enter | input | 1 | Receive mode entered or restarted |
| in_pkt | output | 1 | Packet in progress |
| pkt_good | output | 1 | Packet received with good CRC, not yet read |
| crc_match | output | 1 | Most recent CRC comparison matched |

## Verification
The hardest cases to reach from the ports are the collisions. One is a sync strobe landing with an end-of-packet or an abort in the same cycle. Another is a FIFO read landing on the cycle a passing CRC completes. A third is a receive restart meeting a CRC result. The stimulus builds these on purpose: it first drives a flag into the state where the collision matters, then fires both strobes together. It repeats this in both directions, so an abort that belongs to the other direction is also seen to do nothing. A long stretch of random strobes follows, checked against a scoreboard model.

// File: rtl/pkt_status_pkg.sv
package pkt_status_pkg;
   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } pkt_dir_e;

   localparam int unsigned N_STATUS  = 3;
   localparam int unsigned IDX_ACT   = 0;
   localparam int unsigned IDX_GOOD  = 1;
   localparam int unsigned IDX_MATCH = 2;
endpackage

// File: rtl/pkt_active_flag.sv
module pkt_active_flag
   import pkt_status_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dir_tx,
   input  logic sync_evt,
   input  logic eop_evt,
   input  logic addr_fail,
   input  logic rx_ovf,
   input  logic tx_udf,
   output logic act
);
   logic     abort;
   logic     clr;
   pkt_dir_e dir;

   assign dir = pkt_dir_e'(dir_tx);

   always_comb begin
      unique case (dir)
         DIR_TX:  abort = tx_udf;
         default: abort = addr_fail | rx_ovf;
      endcase
   end

   assign clr = abort | eop_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        act <= 1'b0;
      else if (clr)      act <= 1'b0;
      else if (sync_evt) act <= 1'b1;
   end
endmodule

// File: rtl/pkt_good_flag.sv
module pkt_good_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic crc_done,
   input  logic crc_pass,
   input  logic rx_rd,
   output logic good
);
   logic set_ok;
   assign set_ok = crc_done & crc_pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             good <= 1'b0;
      else if (set_ok)        good <= 1'b1;
      else if (good && rx_rd) good <= 1'b0;
   end
endmodule

// File: rtl/crc_last_flag.sv
module crc_last_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic crc_done,
   input  logic crc_pass,
   input  logic rx_enter,
   output logic match
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        match <= 1'b0;
      else if (rx_enter) match <= 1'b0;
      else if (crc_done) match <= crc_pass;
   end
endmodule

// File: rtl/pkt_status_track.sv
module pkt_status_track
   import pkt_status_pkg::*;
#(
   parameter logic [N_STATUS-1:0] INV_MASK = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_tx,
   input  logic sync_evt,
   input  logic eop_evt,
   input  logic addr_fail,
   input  logic rx_ovf,
   input  logic tx_udf,
   input  logic crc_done,
   input  logic crc_pass,
   input  logic rx_rd,
   input  logic rx_enter,
   output logic in_pkt,
   output logic pkt_good,
   output logic crc_match
);
   localparam int unsigned LAST_IDX = N_STATUS - 1;

   logic                act_q;
   logic                good_q;
   logic                match_q;
   logic [LAST_IDX:0]   flags;
   logic [LAST_IDX:0]   outs;

   if (IDX_ACT == IDX_GOOD || IDX_GOOD == IDX_MATCH || IDX_ACT == IDX_MATCH) begin : g_bad_idx
      $error("status indices must be distinct");
   end

   pkt_active_flag u_act (
      .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .sync_evt(sync_evt),
      .eop_evt(eop_evt), .addr_fail(addr_fail), .rx_ovf(rx_ovf),
      .tx_udf(tx_udf), .act(act_q)
   );

   pkt_good_flag u_good (
      .clk(clk), .rst_n(rst_n), .crc_done(crc_done), .crc_pass(crc_pass),
      .rx_rd(rx_rd), .good(good_q)
   );

   crc_last_flag u_match (
      .clk(clk), .rst_n(rst_n), .crc_done(crc_done), .crc_pass(crc_pass),
      .rx_enter(rx_enter), .match(match_q)
   );

   always_comb begin
      flags            = '0;
      flags[IDX_ACT]   = act_q;
      flags[IDX_GOOD]  = good_q;
      flags[IDX_MATCH] = match_q;
   end

   for (genvar i = 0; i < N_STATUS; i++) begin : g_pol
      if (INV_MASK[i]) begin : g_inv
         assign outs[i] = ~flags[i];
      end else begin : g_pass
         assign outs[i] = flags[i];
      end
   end

   assign in_pkt    = outs[IDX_ACT];
   assign pkt_good  = outs[IDX_GOOD];
   assign crc_match = outs[IDX_MATCH];
endmodule

// File: rtl/pkt_status_chk.sv
module pkt_status_chk (
   input logic clk,
   input logic rst_n,
   input logic dir_tx,
   input logic sync_evt,
   input logic eop_evt,
   input logic addr_fail,
   input logic rx_ovf,
   input logic tx_udf,
   input logic crc_done,
   input logic crc_pass,
   input logic rx_rd,
   input logic rx_enter,
   input logic act,
   input logic good,
   input logic match
);
   logic rx_ab;
   logic tx_ab;
   assign rx_ab = !dir_tx && (addr_fail || rx_ovf);
   assign tx_ab = dir_tx && tx_udf;

   a_r2_sync_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sync_evt && !eop_evt && !rx_ab && !tx_ab |=> act);
   a_r3_eop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      eop_evt |=> !act);
   a_r4_rx_abort: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ab |=> !act);
   a_r4_rx_ignores_udf: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_tx && act && !addr_fail && !rx_ovf && !eop_evt |=> act);
   a_r5_tx_abort: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ab |=> !act);
   a_r5_tx_ignores_rx: assert property (@(posedge clk) disable iff (!rst_n)
      dir_tx && act && !tx_udf && !eop_evt |=> act);
   a_r7_good_set: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done && crc_pass |=> good);
   a_r8_good_read: assert property (@(posedge clk) disable iff (!rst_n)
      good && rx_rd && !(crc_done && crc_pass) |=> !good);
   a_r8_good_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !good && !(crc_done && crc_pass) |=> !good);
   a_r9_match_load: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done && !rx_enter |=> match == $past(crc_pass));
   a_r9_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_done && !rx_enter |=> $stable(match));
   a_r10_enter_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enter |=> !match);
endmodule

bind pkt_status_track pkt_status_chk u_chk (
   .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .sync_evt(sync_evt),
   .eop_evt(eop_evt), .addr_fail(addr_fail), .rx_ovf(rx_ovf),
   .tx_udf(tx_udf), .crc_done(crc_done), .crc_pass(crc_pass),
   .rx_rd(rx_rd), .rx_enter(rx_enter), .act(act_q), .good(good_q),
   .match(match_q)
);

// File: tb/sim_pkt_status_track.sv
`timescale 1ns/1ps
module sim_pkt_status_track;
   typedef struct {
      logic [2:0] exp;
      string      tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_tx = 0, sync_evt = 0, eop_evt = 0, addr_fail = 0, rx_ovf = 0;
   logic tx_udf = 0, crc_done = 0, crc_pass = 0, rx_rd = 0, rx_enter = 0;
   logic in_pkt, pkt_good, crc_match;
   logic in_pkt1, pkt_good1, crc_match1;

   int   n_vec = 0;
   int   n_bad = 0;
   logic m_act = 0, m_good = 0, m_match = 0;
   item_t sb[$];
   bit   done = 0;

   always #5 clk = ~clk;

   pkt_status_track u0 (
      .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .sync_evt(sync_evt),
      .eop_evt(eop_evt), .addr_fail(addr_fail), .rx_ovf(rx_ovf),
      .tx_udf(tx_udf), .crc_done(crc_done), .crc_pass(crc_pass),
      .rx_rd(rx_rd), .rx_enter(rx_enter), .in_pkt(in_pkt),
      .pkt_good(pkt_good), .crc_match(crc_match)
   );

   pkt_status_track #(.INV_MASK(3'b101)) u1 (
      .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .sync_evt(sync_evt),
      .eop_evt(eop_evt), .addr_fail(addr_fail), .rx_ovf(rx_ovf),
      .tx_udf(tx_udf), .crc_done(crc_done), .crc_pass(crc_pass),
      .rx_rd(rx_rd), .rx_enter(rx_enter), .in_pkt(in_pkt1),
      .pkt_good(pkt_good1), .crc_match(crc_match1)
   );

   task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {match,good,in_pkt} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, the model predicts the registered result
   task automatic step(input logic d, input logic s, input logic e, input logic af,
                       input logic ov, input logic ud, input logic cd, input logic cp,
                       input logic rd, input logic en, input string tag);
      item_t it;
      logic  clr;
      @(negedge clk);
      dir_tx = d; sync_evt = s; eop_evt = e; addr_fail = af; rx_ovf = ov;
      tx_udf = ud; crc_done = cd; crc_pass = cp; rx_rd = rd; rx_enter = en;
      clr = e | (d ? ud : (af | ov));
      if (clr) m_act = 0; else if (s) m_act = 1;
      if (cd && cp) m_good = 1; else if (rd) m_good = 0;
      if (en) m_match = 0; else if (cd) m_match = cp;
      it.exp = {m_match, m_good, m_act};
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle();
      step(dir_tx, 0,0,0,0,0,0,0,0,0, "idle hold");
   endtask

   // monitor: compares after every active edge
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check({crc_match, pkt_good, in_pkt}, it.exp, it.tag);
         check({crc_match1, pkt_good1, in_pkt1} ^ 3'b101, it.exp, "R11 inverted outputs");
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({crc_match, pkt_good, in_pkt}, 3'b000, "R1 reset state");
      check({crc_match1, pkt_good1, in_pkt1}, 3'b101, "R11 reset polarity");
      rst_n = 1;
      // R2 sync sets and holds
      step(0, 1,0,0,0,0,0,0,0,0, "R2 sync sets");
      idle(); idle();
      // R3 eop clears
      step(0, 0,1,0,0,0,0,0,0,0, "R3 eop clears");
      // R4 receive aborts, udf ignored
      step(0, 1,0,0,0,0,0,0,0,0, "R2 sync again");
      step(0, 0,0,0,0,1,0,0,0,0, "R4 udf ignored in rx");
      step(0, 0,0,1,0,0,0,0,0,0, "R4 addr fail clears");
      step(0, 1,0,0,0,0,0,0,0,0, "R2 sync again");
      step(0, 0,0,0,1,0,0,0,0,0, "R4 overflow clears");
      // R5 transmit
      step(1, 1,0,0,0,0,0,0,0,0, "R2 sync in tx");
      step(1, 0,0,1,1,0,0,0,0,0, "R5 rx aborts ignored in tx");
      step(1, 0,0,0,0,1,0,0,0,0, "R5 underflow clears");
      // R6 collisions
      step(1, 1,0,0,0,1,0,0,0,0, "R6 udf beats sync");
      step(0, 1,0,0,1,0,0,0,0,0, "R6 overflow beats sync");
      step(0, 1,0,1,0,0,0,0,0,0, "R6 addr fail beats sync");
      step(0, 1,1,0,0,0,0,0,0,0, "R6 eop beats sync");
      step(1, 1,0,1,0,0,0,0,0,0, "R6 rx abort not valid in tx");
      // R7/R8 good flag
      step(0, 0,0,0,0,0,0,0,1,0, "R8 read while clear ignored");
      step(0, 0,0,0,0,0,1,0,0,0, "R7 failing crc no set");
      step(0, 0,0,0,0,0,1,1,0,0, "R7 passing crc sets");
      idle();
      step(0, 0,0,0,0,0,0,0,1,0, "R8 first read clears");
      step(0, 0,0,0,0,0,1,1,1,0, "R8 set wins over read");
      step(0, 0,0,0,0,0,0,0,1,0, "R8 read clears again");
      // R9/R10 last crc
      step(0, 0,0,0,0,0,1,1,0,0, "R9 load pass");
      idle();
      step(0, 0,0,0,0,0,1,0,0,0, "R9 load fail");
      step(0, 0,0,0,0,0,1,1,0,0, "R9 load pass again");
      step(0, 0,0,0,0,0,0,0,0,1, "R10 enter clears");
      step(0, 0,0,0,0,0,1,1,0,0, "R9 load pass");
      step(0, 0,0,0,0,0,1,1,0,1, "R10 enter beats crc");
      // random mix
      for (int k = 0; k < 400; k++) begin
         logic [9:0] r;
         r = 10'($urandom);
         step(r[0], r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7], r[8] & r[2],
              r[9], r[3], r[5], r[7] & r[9] & r[1], "random R2 R6 R8 R9 R10");
      end
      idle();
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule